// File: doc/BRIEF.md
# Successor-ID and Diagnostic Flag Unit

This block holds the status that a token-passing network node shows to its host about its place in the ring. An internal sequencer loads the ID of the node that will next receive the token into an 8-bit successor register. Each load raises a new-successor flag. Alongside it sits a diagnostic register made of event bits that the sequencer sets with one-cycle pulses. Each kind of bit has its own clearing rule. Ordinary event bits clear when the host reads the diagnostic register. The new-successor flag clears only when the host reads the successor register. The excessive-NAK bit clears only on an explicit clear-flags command.

The host reads through a strobe and a register select. The read value is captured on the clock edge of the strobe, before any clear on that edge takes effect, so the host always sees the bits that were set. A set event that lands on the same edge as its clear is kept. The interrupt output combines the new-successor flag and the excessive-NAK flag, each under its own mask bit. A hardware reset (asynchronous) and a software reset (synchronous) both return every register to zero.

Top module: `ndf_flag_unit`

## Requirements
- R1: After hardware reset the successor ID reads 0x00, irq is 0 for every mask setting, and a diagnostic read returns 0000 000L, where L is the value of `line_live`.
- R2: A `succ_load` pulse stores `succ_data` as the successor ID and sets the new-successor flag on the same clock edge.
- R3: A read with `rd_sel` = 0 returns the successor ID and clears the new-successor flag. A read with `rd_sel` = 1 leaves that flag unchanged.
- R4: The diagnostic word has this layout: bit 0 is the live state of `line_live`, bit 1 mirrors the new-successor flag, bit 2 is the excessive-NAK bit, and bits 7..3 are the event bits set by `seq_evt[4:0]`. Any other `rd_sel` value reads 0x00.
- R5: A diagnostic read clears event bits 7..3 and returns their value from before the clear.
- R6: The excessive-NAK bit is set by `seq_nak` and keeps its value through reads of either register. Only `clr_flags` or a reset clears it.
- R7: When a set and a clear reach the same bit on one edge, the bit ends set. The read on that edge still shows the old value.
- R8: `irq` = (new-successor flag AND `irq_mask[0]`) OR (excessive-NAK bit AND `irq_mask[1]`), with no added latency.
- R9: A one-cycle `sw_rst` clears the successor ID, all flags and `rd_data` on the next edge. It takes priority over any set on that edge.
- R10: `rd_data` updates one cycle after an edge with `rd_stb` high, and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_rst | input | 1 | Synchronous software reset, active high |
| seq_evt | input | 5 | Diagnostic event pulses from the sequencer |
| seq_nak | input | 1 | Excessive-NAK event pulse |
| succ_load | input | 1 | Successor-ID load strobe |
| succ_data | input | 8 | Successor ID to load |
| line_live | input | 1 | Live line state shown in diagnostic bit 0 |
| rd_stb | input | 1 | Host read strobe |
| rd_sel | input | 2 | Register select: 0 successor, 1 diagnostic |
| clr_flags | input | 1 | Clear-flags command strobe |
| irq_mask | input | 2 | Interrupt masks: [0] new successor, [1] excessive NAK |
| rd_data | output | 8 | Captured read value |
| irq | output | 1 | Interrupt request |

## Verification
Every flag can see a set and a clear on the same edge. An event pulse can meet a diagnostic read, a successor load can meet a successor read, and an excessive-NAK pulse can meet the clear-flags command. The bench drives each pair on one edge. It then judges two things: the captured read must show the pre-edge value, and a following read must show that the bit survived. A software reset driven together with a load is also checked, to confirm that the reset wins.

// File: rtl/ndf_pkg.sv
package ndf_pkg;
   typedef enum logic [1:0] {
      SEL_SUCC = 2'd0,
      SEL_DIAG = 2'd1
   } ndf_sel_e;

   localparam int DIAG_LIVE_BIT = 0;
   localparam int DIAG_NEWS_BIT = 1;
   localparam int DIAG_NAK_BIT  = 2;
   localparam int DIAG_EVT_LSB  = 3;
endpackage

// File: rtl/ndf_sticky_bit.sv
module ndf_sticky_bit (
   input  logic clk,
   input  logic hw_rst_n,
   input  logic sw_rst,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge hw_rst_n) begin
      if (!hw_rst_n)   q_o <= 1'b0;
      else if (sw_rst) q_o <= 1'b0;
      else             q_o <= set_i | (q_o & ~clr_i);
   end

   // R7: a set on the same edge as a clear keeps the bit
   p_set_wins_r7: assert property (@(posedge clk) disable iff (!hw_rst_n)
      (set_i && !sw_rst) |=> q_o);
endmodule

// File: rtl/ndf_succ_reg.sv
module ndf_succ_reg #(
   parameter int ID_W = 8
) (
   input  logic            clk,
   input  logic            hw_rst_n,
   input  logic            sw_rst,
   input  logic            load_i,
   input  logic [ID_W-1:0] load_data_i,
   input  logic            rd_clr_i,
   output logic [ID_W-1:0] id_o,
   output logic            flag_o
);
   always_ff @(posedge clk or negedge hw_rst_n) begin
      if (!hw_rst_n)   id_o <= '0;
      else if (sw_rst) id_o <= '0;
      else if (load_i) id_o <= load_data_i;
   end

   ndf_sticky_bit u_flag (
      .clk(clk), .hw_rst_n(hw_rst_n), .sw_rst(sw_rst),
      .set_i(load_i), .clr_i(rd_clr_i), .q_o(flag_o)
   );

   p_id_load_r2: assert property (@(posedge clk) disable iff (!hw_rst_n)
      (load_i && !sw_rst) |=> (id_o == $past(load_data_i)));
   p_flag_hold_r3: assert property (@(posedge clk) disable iff (!hw_rst_n)
      (flag_o && !rd_clr_i && !sw_rst) |=> flag_o);
   p_swrst_r9: assert property (@(posedge clk) disable iff (!hw_rst_n)
      sw_rst |=> (id_o == '0 && !flag_o));
endmodule

// File: rtl/ndf_diag_bits.sv
module ndf_diag_bits #(
   parameter int N_EVT = 5
) (
   input  logic             clk,
   input  logic             hw_rst_n,
   input  logic             sw_rst,
   input  logic [N_EVT-1:0] evt_i,
   input  logic             nak_i,
   input  logic             rd_clr_i,
   input  logic             cmd_clr_i,
   output logic [N_EVT-1:0] evt_o,
   output logic             nak_o
);
   for (genvar g = 0; g < N_EVT; g++) begin : g_evt
      ndf_sticky_bit u_bit (
         .clk(clk), .hw_rst_n(hw_rst_n), .sw_rst(sw_rst),
         .set_i(evt_i[g]), .clr_i(rd_clr_i), .q_o(evt_o[g])
      );
   end

   ndf_sticky_bit u_nak (
      .clk(clk), .hw_rst_n(hw_rst_n), .sw_rst(sw_rst),
      .set_i(nak_i), .clr_i(cmd_clr_i), .q_o(nak_o)
   );

   p_evt_clear_r5: assert property (@(posedge clk) disable iff (!hw_rst_n)
      (rd_clr_i && evt_i == '0) |=> (evt_o == '0));
   p_nak_sticky_r6: assert property (@(posedge clk) disable iff (!hw_rst_n)
      (nak_o && !cmd_clr_i && !sw_rst) |=> nak_o);
endmodule

// File: rtl/ndf_read_port.sv
module ndf_read_port #(
   parameter int W      = 8,
   parameter bit RD_REG = 1'b1
) (
   input  logic         clk,
   input  logic         hw_rst_n,
   input  logic         sw_rst,
   input  logic         rd_stb_i,
   input  logic [W-1:0] value_i,
   output logic [W-1:0] rd_data_o
);
   if (RD_REG) begin : g_reg
      always_ff @(posedge clk or negedge hw_rst_n) begin
         if (!hw_rst_n)     rd_data_o <= '0;
         else if (sw_rst)   rd_data_o <= '0;
         else if (rd_stb_i) rd_data_o <= value_i;
      end

      p_capture_r10: assert property (@(posedge clk) disable iff (!hw_rst_n)
         (rd_stb_i && !sw_rst) |=> (rd_data_o == $past(value_i)));
      p_hold_r10: assert property (@(posedge clk) disable iff (!hw_rst_n)
         (!rd_stb_i && !sw_rst) |=> $stable(rd_data_o));
   end else begin : g_comb
      logic unused_ok;
      assign unused_ok = clk ^ hw_rst_n ^ sw_rst ^ rd_stb_i;
      assign rd_data_o = value_i;
   end
endmodule

// File: rtl/ndf_flag_unit.sv
module ndf_flag_unit #(
   parameter int ID_W   = 8,
   parameter int REG_W  = 8,
   parameter int N_EVT  = 5,
   parameter bit RD_REG = 1'b1
) (
   input  logic             clk,
   input  logic             hw_rst_n,
   input  logic             sw_rst,
   input  logic [N_EVT-1:0] seq_evt,
   input  logic             seq_nak,
   input  logic             succ_load,
   input  logic [ID_W-1:0]  succ_data,
   input  logic             line_live,
   input  logic             rd_stb,
   input  logic [1:0]       rd_sel,
   input  logic             clr_flags,
   input  logic [1:0]       irq_mask,
   output logic [REG_W-1:0] rd_data,
   output logic             irq
);
   import ndf_pkg::*;

   localparam int EVT_MSB = DIAG_EVT_LSB + N_EVT - 1;
   localparam int PAD_W   = REG_W - (EVT_MSB + 1);

   if (EVT_MSB >= REG_W) begin : g_chk_evt
      $error("diagnostic event bits do not fit in REG_W");
   end
   if (ID_W > REG_W) begin : g_chk_id
      $error("ID_W wider than REG_W");
   end

   logic             rd_succ, rd_diag;
   logic [ID_W-1:0]  succ_id;
   logic             news_flag, nak_flag;
   logic [N_EVT-1:0] evt_q;
   logic [REG_W-1:0] diag_word, succ_word, sel_word;

   assign rd_succ = rd_stb && (rd_sel == SEL_SUCC);
   assign rd_diag = rd_stb && (rd_sel == SEL_DIAG);

   ndf_succ_reg #(.ID_W(ID_W)) u_succ (
      .clk(clk), .hw_rst_n(hw_rst_n), .sw_rst(sw_rst),
      .load_i(succ_load), .load_data_i(succ_data), .rd_clr_i(rd_succ),
      .id_o(succ_id), .flag_o(news_flag)
   );

   ndf_diag_bits #(.N_EVT(N_EVT)) u_diag (
      .clk(clk), .hw_rst_n(hw_rst_n), .sw_rst(sw_rst),
      .evt_i(seq_evt), .nak_i(seq_nak), .rd_clr_i(rd_diag),
      .cmd_clr_i(clr_flags), .evt_o(evt_q), .nak_o(nak_flag)
   );

   if (PAD_W > 0) begin : g_pad
      assign diag_word[REG_W-1:EVT_MSB+1] = '0;
   end
   assign diag_word[EVT_MSB:DIAG_EVT_LSB] = evt_q;
   assign diag_word[DIAG_NAK_BIT]         = nak_flag;
   assign diag_word[DIAG_NEWS_BIT]        = news_flag;
   assign diag_word[DIAG_LIVE_BIT]        = line_live;

   if (ID_W < REG_W) begin : g_id_ext
      assign succ_word = {{(REG_W-ID_W){1'b0}}, succ_id};
   end else begin : g_id_full
      assign succ_word = succ_id;
   end

   always_comb begin
      unique case (rd_sel)
         SEL_SUCC: sel_word = succ_word;
         SEL_DIAG: sel_word = diag_word;
         default:  sel_word = '0;
      endcase
   end

   ndf_read_port #(.W(REG_W), .RD_REG(RD_REG)) u_rd (
      .clk(clk), .hw_rst_n(hw_rst_n), .sw_rst(sw_rst),
      .rd_stb_i(rd_stb), .value_i(sel_word), .rd_data_o(rd_data)
   );

   assign irq = (news_flag & irq_mask[0]) | (nak_flag & irq_mask[1]);

   // R3: a diagnostic read never clears the new-successor flag
   p_diag_keeps_news_r3: assert property (@(posedge clk) disable iff (!hw_rst_n)
      (news_flag && rd_diag && !sw_rst) |=> news_flag);
   p_load_sets_r2: assert property (@(posedge clk) disable iff (!hw_rst_n)
      (succ_load && !sw_rst && irq_mask[0]) |=> (irq || !irq_mask[0]));
   p_irq_off_r8: assert property (@(posedge clk) disable iff (!hw_rst_n)
      (irq_mask == 2'b00) |-> !irq);
endmodule

// File: tb/ndf_flag_unit_bench.sv
`timescale 1ns/100ps
module ndf_flag_unit_bench;
   logic       clk = 1'b0;
   logic       hw_rst_n = 1'b0;
   logic       sw_rst = 1'b0;
   logic [4:0] seq_evt = '0;
   logic       seq_nak = 1'b0;
   logic       succ_load = 1'b0;
   logic [7:0] succ_data = '0;
   logic       line_live = 1'b0;
   logic       rd_stb = 1'b0;
   logic [1:0] rd_sel = '0;
   logic       clr_flags = 1'b0;
   logic [1:0] irq_mask = '0;
   logic [7:0] rd_data;
   logic       irq;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   ndf_flag_unit u_ndf_flag_unit (
      .clk(clk), .hw_rst_n(hw_rst_n), .sw_rst(sw_rst), .seq_evt(seq_evt),
      .seq_nak(seq_nak), .succ_load(succ_load), .succ_data(succ_data),
      .line_live(line_live), .rd_stb(rd_stb), .rd_sel(rd_sel),
      .clr_flags(clr_flags), .irq_mask(irq_mask), .rd_data(rd_data), .irq(irq)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic clear_inputs();
      seq_evt = '0; seq_nak = 0; succ_load = 0; rd_stb = 0;
      clr_flags = 0; sw_rst = 0;
   endtask

   // one read cycle; rd_data checked after the capturing edge
   task automatic do_read(logic [1:0] sel, logic [7:0] exp, string req);
      rd_sel = sel; rd_stb = 1;
      tick();
      clear_inputs();
      check(req, rd_data, exp);
   endtask

   task automatic t_reset();
      hw_rst_n = 0;
      tick();
      hw_rst_n = 1;
      tick();
      for (int m = 0; m < 4; m++) begin
         irq_mask = m[1:0];
         #0.1 check("R1 irq", {7'd0, irq}, 8'h00);
      end
      irq_mask = 2'b00;
      do_read(2'd0, 8'h00, "R1 succ");
      line_live = 1;
      do_read(2'd1, 8'h01, "R1 diag live");
      line_live = 0;
      do_read(2'd1, 8'h00, "R1 diag");
      do_read(2'd2, 8'h00, "R4 unused sel");
   endtask

   task automatic t_load();
      succ_data = 8'hA5; succ_load = 1;
      tick();
      clear_inputs();
      irq_mask = 2'b01;
      #0.1 check("R8 irq news", {7'd0, irq}, 8'h01);
      irq_mask = 2'b10;
      #0.1 check("R8 irq masked", {7'd0, irq}, 8'h00);
      irq_mask = 2'b00;
      do_read(2'd1, 8'h02, "R2 news in diag");
      do_read(2'd1, 8'h02, "R3 diag keeps news");
      do_read(2'd0, 8'hA5, "R2 succ id");
      do_read(2'd1, 8'h00, "R3 succ read clears");
   endtask

   task automatic t_events();
      logic [4:0] pats [3] = '{5'b10101, 5'b01010, 5'b11111};
      foreach (pats[i]) begin
         seq_evt = pats[i];
         tick();
         clear_inputs();
         do_read(2'd1, {pats[i], 3'b000}, "R5 event read");
         do_read(2'd1, 8'h00, "R5 event cleared");
      end
      seq_evt = 5'b00001; tick(); clear_inputs();
      line_live = 1;
      do_read(2'd1, 8'h09, "R4 live plus event");
      line_live = 0;
   endtask

   task automatic t_nak();
      seq_nak = 1; tick(); clear_inputs();
      irq_mask = 2'b10;
      #0.1 check("R8 irq nak", {7'd0, irq}, 8'h01);
      irq_mask = 2'b00;
      do_read(2'd1, 8'h04, "R6 nak read");
      do_read(2'd1, 8'h04, "R6 nak survives diag read");
      do_read(2'd0, 8'hA5, "R6 succ read");
      do_read(2'd1, 8'h04, "R6 nak survives succ read");
      clr_flags = 1; tick(); clear_inputs();
      do_read(2'd1, 8'h00, "R6 clr_flags");
   endtask

   task automatic t_collide();
      seq_evt = 5'b00001; tick(); clear_inputs();
      seq_evt = 5'b00100;
      do_read(2'd1, 8'h08, "R7 read shows old");
      do_read(2'd1, 8'h20, "R7 event kept");
      succ_data = 8'h11; succ_load = 1; tick(); clear_inputs();
      succ_data = 8'h22; succ_load = 1;
      do_read(2'd0, 8'h11, "R7 succ read old");
      do_read(2'd1, 8'h02, "R7 news kept");
      do_read(2'd0, 8'h22, "R7 new id");
      seq_nak = 1; tick(); clear_inputs();
      seq_nak = 1; clr_flags = 1; tick(); clear_inputs();
      do_read(2'd1, 8'h04, "R7 nak kept");
      clr_flags = 1; tick(); clear_inputs();
   endtask

   task automatic t_hold();
      do_read(2'd0, 8'h22, "R10 read");
      succ_data = 8'h33; succ_load = 1; seq_evt = 5'b11111; seq_nak = 1;
      tick(); clear_inputs();
      tick();
      check("R10 hold", rd_data, 8'h22);
   endtask

   task automatic t_swrst();
      succ_data = 8'h5C; succ_load = 1; seq_evt = 5'b10000; seq_nak = 1;
      tick(); clear_inputs();
      sw_rst = 1; succ_load = 1; succ_data = 8'h77; seq_nak = 1;
      tick(); clear_inputs();
      check("R9 rd_data", rd_data, 8'h00);
      irq_mask = 2'b11;
      #0.1 check("R9 irq", {7'd0, irq}, 8'h00);
      irq_mask = 2'b00;
      do_read(2'd0, 8'h00, "R9 succ");
      do_read(2'd1, 8'h00, "R9 diag");
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_load();
      t_events();
      t_nak();
      t_collide();
      t_hold();
      t_swrst();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule